// File: doc/BRIEF.md
# Oscillator Fault Monitor

This block supervises three clock generators from a fast, free-running monitor clock: a low-frequency crystal that can run in a low or a high frequency mode, a high-frequency crystal, and a digitally tuned oscillator. Each crystal input comes from its own clock domain and is synchronised first. Any change of level on it counts as an edge. A crystal is declared faulty when no edge arrives for more than a programmable number of monitor cycles. The tuned oscillator is declared faulty when its tap code sits at either end of its range, because the frequency loop can no longer correct it there.

Every fault raises its own sticky flag. Every flag stays set until software pulses the matching clear strobe. The first crystal has two flags, one for each of its operating modes, and a fault counts against the mode that is selected at the time. A combined fault flag follows any individual flag and can be cleared only once all individual flags are clear. Per-crystal validity outputs tell the clock selector which crystals it may use.

Top module: `osc_fault_monitor`

## Requirements
- R1: A crystal that changes level at least once every `timeout_i` monitor cycles never raises its fault. If a crystal shows no edge for more than `timeout_i` cycles after synchronisation, its fault flag is set.
- R2: A fault of the first crystal sets `status_o[1]` when `xt1_hf_mode_i` is 0 and sets `status_o[2]` when it is 1. A fault of the second crystal sets `status_o[3]`.
- R3: `status_o[0]` is set on the clock edge after `dco_tap_i` is all zeros or all ones.
- R4: A set flag in `status_o[3:0]` stays set until the clear strobe with the same index in `clr_flag_i` is high at a clock edge.
- R5: A clear strobe takes priority over a fault cause in the same cycle. If the cause is still present, the flag sets again on the following clock edge.
- R6: `any_fault_o` is set on the same clock edge as any individual flag.
- R7: `clr_all_i` clears `any_fault_o` only when `status_o[3:0]` is all zero and no fault cause is present. Otherwise `any_fault_o` stays high.
- R8: `xt1_valid_o` is high only while the flag of the currently selected mode of the first crystal is clear. `xt2_valid_o` is high only while `status_o[3]` is clear.
- R9: `status_o[7:4]` always reads 0.
- R10: After reset, all flags and `any_fault_o` are 0 and both validity outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xt1_clk_i | input | 1 | First crystal clock (asynchronous) |
| xt2_clk_i | input | 1 | Second crystal clock (asynchronous) |
| xt1_hf_mode_i | input | 1 | First crystal mode: 0 low, 1 high frequency |
| dco_tap_i | input | TAP_W | Tuned oscillator tap code |
| timeout_i | input | CNT_W | Edge-gap limit in monitor cycles |
| clr_flag_i | input | 4 | Per-flag clear strobes, same bit order as status_o[3:0] |
| clr_all_i | input | 1 | Combined flag clear strobe |
| status_o | output | 8 | Flags: 0 oscillator, 1 xt1 low mode, 2 xt1 high mode, 3 xt2; 7:4 zero |
| any_fault_o | output | 1 | Combined fault flag |
| xt1_valid_o | output | 1 | First crystal usable by the selector |
| xt2_valid_o | output | 1 | Second crystal usable by the selector |

## Verification
The bench stops a crystal and checks the flag at two points: before the gap limit is reached and after it has passed. A counter that is off by a wide margin or never expires fails one of these two checks. It clears a flag while the cause persists. A design that lets the cause win the clear would show no zero cycle. A design that forgets the cause would never set the flag again. It tries to clear the combined flag while an individual flag is still set, and it switches the crystal mode during a fault. A design that clears too early, or that stores the fault under the wrong mode flag, shows a different status word. Random tap codes, weighted toward both range ends and mixed with random strobes, are compared every cycle against a model of the sticky and combined flags.

// File: rtl/osc_fault_pkg.sv
package osc_fault_pkg;
  localparam int unsigned NFLAG     = 4;
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned IDX_DCO   = 0;
  localparam int unsigned IDX_X1_LF = 1;
  localparam int unsigned IDX_X1_HF = 2;
  localparam int unsigned IDX_X2    = 3;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // any level change counts as activity
  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/osc_edge_watchdog.sv
module osc_edge_watchdog #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             miss_o
);
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (edge_i)          gap_q <= '0;
    else if (gap_q < limit_i) gap_q <= gap_q + 1'b1;
  end

  // >= keeps the fault stable if the limit is lowered on the fly
  assign miss_o = !edge_i && (gap_q >= limit_i);
endmodule

// File: rtl/osc_flag_bank.sv
module osc_flag_bank
  import osc_fault_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t cause_i,
  input  flag_vec_t clr_i,
  input  logic      clr_all_i,
  output flag_vec_t flag_o,
  output logic      any_o
);
  flag_vec_t flag_q;
  logic      any_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (clr_i[i]) flag_q[i] <= 1'b0;          // clear wins this cycle
      else if (cause_i[i]) flag_q[i] <= 1'b1;
    end
  end

  logic any_clr_ok;
  assign any_clr_ok = clr_all_i && (flag_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          any_q <= 1'b0;
    else if (|cause_i)    any_q <= 1'b1;
    else if (any_clr_ok)  any_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign any_o  = any_q;
endmodule

// File: rtl/osc_fault_monitor.sv
module osc_fault_monitor
  import osc_fault_pkg::*;
#(
  parameter int unsigned TAP_W       = 5,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xt1_clk_i,
  input  logic             xt2_clk_i,
  input  logic             xt1_hf_mode_i,
  input  logic [TAP_W-1:0] dco_tap_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic [3:0]       clr_flag_i,
  input  logic             clr_all_i,
  output logic [7:0]       status_o,
  output logic             any_fault_o,
  output logic             xt1_valid_o,
  output logic             xt2_valid_o
);
  localparam int unsigned NXT = 2;
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  logic [NXT-1:0] xt_clk;
  logic [NXT-1:0] xt_edge;
  logic [NXT-1:0] xt_miss;
  assign xt_clk = {xt2_clk_i, xt1_clk_i};

  for (genvar i = 0; i < NXT; i++) begin : g_xt
    osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(xt_clk[i]),
      .edge_o (xt_edge[i])
    );
    osc_edge_watchdog #(.CNT_W(CNT_W)) u_wdog (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .edge_i (xt_edge[i]),
      .limit_i(timeout_i),
      .miss_o (xt_miss[i])
    );
  end

  flag_vec_t cause;
  flag_vec_t flags;
  always_comb begin
    cause            = '0;
    cause[IDX_DCO]   = (dco_tap_i == '0) || (dco_tap_i == TAP_MAX);
    cause[IDX_X1_LF] = xt_miss[0] && !xt1_hf_mode_i;
    cause[IDX_X1_HF] = xt_miss[0] &&  xt1_hf_mode_i;
    cause[IDX_X2]    = xt_miss[1];
  end

  osc_flag_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cause_i  (cause),
    .clr_i    (clr_flag_i),
    .clr_all_i(clr_all_i),
    .flag_o   (flags),
    .any_o    (any_fault_o)
  );

  assign status_o    = {{(STATUS_W-NFLAG){1'b0}}, flags};
  assign xt1_valid_o = xt1_hf_mode_i ? !flags[IDX_X1_HF] : !flags[IDX_X1_LF];
  assign xt2_valid_o = !flags[IDX_X2];
endmodule

// File: rtl/osc_fault_monitor_chk.sv
module osc_fault_monitor_chk #(
  parameter int unsigned TAP_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TAP_W-1:0] dco_tap_i,
  input logic [3:0]       clr_flag_i,
  input logic [7:0]       status_o,
  input logic             any_fault_o
);
  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:4] == 4'b0);

  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o[3:0] & ~clr_flag_i) & ~status_o[3:0]) == 4'b0));

  assert_tap_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dco_tap_i == '0 || dco_tap_i == {TAP_W{1'b1}}) && !clr_flag_i[0]) |=> status_o[0]);

  assert_any_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:0] != 4'b0) |-> any_fault_o);

  assert_any_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_fault_o) |-> ($past(status_o[3:0]) == 4'b0));
endmodule

bind osc_fault_monitor osc_fault_monitor_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dco_tap_i  (dco_tap_i),
  .clr_flag_i (clr_flag_i),
  .status_o   (status_o),
  .any_fault_o(any_fault_o)
);

// File: tb/osc_fault_monitor_tb.sv
module osc_fault_monitor_tb;
  localparam int TAP_W = 5;
  localparam int CNT_W = 8;
  localparam int TMO   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xt1 = 1'b0, xt2 = 1'b0, hf = 1'b0;
  logic [TAP_W-1:0] tap = 5'd16;
  logic [CNT_W-1:0] tmo = CNT_W'(TMO);
  logic [3:0] clr = '0;
  logic clr_all = 1'b0;
  logic [7:0] status;
  logic any_f, v1, v2;
  logic run1 = 1'b1, run2 = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  osc_fault_monitor #(.TAP_W(TAP_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .xt1_clk_i(xt1), .xt2_clk_i(xt2),
    .xt1_hf_mode_i(hf), .dco_tap_i(tap), .timeout_i(tmo),
    .clr_flag_i(clr), .clr_all_i(clr_all), .status_o(status),
    .any_fault_o(any_f), .xt1_valid_o(v1), .xt2_valid_o(v2));

  // crystals toggle every 3 monitor cycles while running
  int c1 = 0, c2 = 0;
  always @(negedge clk) begin
    if (run1) begin c1 = c1 + 1; if (c1 >= 3) begin c1 = 0; xt1 = ~xt1; end end
    if (run2) begin c2 = c2 + 1; if (c2 >= 3) begin c2 = 0; xt2 = ~xt2; end end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clr(logic [3:0] c, logic a);
    @(negedge clk);
    clr = c; clr_all = a;
    @(posedge clk); #1;
    clr = '0; clr_all = 1'b0;
  endtask

  function automatic logic tap_end(logic [TAP_W-1:0] t);
    return (t == '0) || (t == '1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic exp_dco, exp_any;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10 reset state
    chk("R10 status", status, 0);
    chk("R10 any", any_f, 0);
    chk("R10 valid", {v1, v2}, 2'b11);

    // R1 running crystals never fault
    cyc(100);
    chk("R1 running", status, 0);

    // R3/R4/R5/R6/R7/R9 random taps and strobes vs model
    void'($urandom(32'h5eed_1234));
    exp_dco = 1'b0; exp_any = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic cause, nd, na;
      @(negedge clk);
      case ($urandom % 4)
        0: tap = '0;
        1: tap = '1;
        default: tap = TAP_W'($urandom);
      endcase
      clr = {3'b000, ($urandom % 4) == 0};
      clr_all = ($urandom % 4) == 0;
      cause = tap_end(tap);
      nd = clr[0] ? 1'b0 : (exp_dco | cause);
      na = cause ? 1'b1 : ((clr_all && !exp_dco) ? 1'b0 : exp_any);
      @(posedge clk); #1;
      exp_dco = nd; exp_any = na;
      chk("R3/R4/R5 dco flag", status[0], exp_dco);
      chk("R6/R7 any", any_f, exp_any);
      chk("R9 reserved", status[7:4], 0);
    end
    @(negedge clk);
    tap = 5'd16; clr = '0; clr_all = 1'b0;
    pulse_clr(4'b0001, 1'b0);
    pulse_clr(4'b0000, 1'b1);
    chk("R7 all clear", {any_f, status}, 0);

    // R1/R2 second crystal stops
    run2 = 1'b0;
    cyc(8);
    chk("R1 before limit", status[3], 0);
    cyc(25);
    chk("R2 xt2 flag", status, 8'h08);
    chk("R6 any with xt2", any_f, 1);
    chk("R8 xt2 invalid", {v1, v2}, 2'b10);
    // R5 clear while cause persists
    pulse_clr(4'b1000, 1'b0);
    chk("R5 cleared cycle", status[3], 0);
    cyc(1);
    chk("R5 re-set", status[3], 1);
    // R7 combined stays while flag set
    run2 = 1'b1;
    cyc(12);
    pulse_clr(4'b0000, 1'b1);
    chk("R7 held by flag", any_f, 1);
    chk("R4 still sticky", status[3], 1);
    pulse_clr(4'b1000, 1'b0);
    cyc(5);
    chk("R4 cleared stays", status[3], 0);
    chk("R8 xt2 valid again", v2, 1);
    chk("R7 any before clr", any_f, 1);
    pulse_clr(4'b0000, 1'b1);
    chk("R7 any cleared", any_f, 0);

    // R2 first crystal, low mode then high mode
    hf = 1'b0; run1 = 1'b0;
    cyc(30);
    chk("R2 xt1 low mode", status, 8'h02);
    chk("R8 xt1 invalid low", v1, 0);
    @(negedge clk); hf = 1'b1;
    cyc(2);
    chk("R2 xt1 high mode", status, 8'h06);
    chk("R8 xt1 invalid high", v1, 0);
    run1 = 1'b1;
    cyc(12);
    pulse_clr(4'b0100, 1'b0);
    cyc(3);
    chk("R8 hf clear valid", v1, 1);
    @(negedge clk); hf = 1'b0;
    cyc(1);
    chk("R8 lf flag still set", v1, 0);
    pulse_clr(4'b0010, 1'b0);
    pulse_clr(4'b0000, 1'b1);
    chk("R4 final clear", {any_f, status}, 0);
    chk("R8 final valid", {v1, v2}, 2'b11);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule